// File: doc/BRIEF.md
# Capture-Compare General Purpose Timer

This block is one 16-bit timer channel. A single mode word picks the count clock from four sources: a tick from a neighbouring timer, every system clock, every sixteenth system clock, or falling edges of an external timer pin. It divides that clock by a programmable prescale of 1 to 256 and advances a counter. The counter is compared against a reference value. When the reference is reached the channel can restart from zero or keep running, drives a pulse or a toggle on its output pin, and raises a sticky event flag.

The same external pin can also snapshot the counter on a selected edge into a capture register, with its own sticky flag. Both flags feed one interrupt line through their enables. A gate pin can stop counting while it is high. Software reaches the mode, reference, counter, capture and event registers through a plain write strobe and a combinational read port. Register addresses: 0 mode, 1 reference, 2 counter, 3 capture, 4 event.

Top module: `gpt_timer`

## Requirements
- R1: After reset the mode, reference, counter, capture and event registers read 0, `toutN` is 1 and `irq` is 0.
- R2: The mode bits [15:8] hold a prescale value P. The counter advances once for every P+1 ticks of the selected source.
- R3: The mode bits [1:0] select the source. 00 is one tick per `cascadeTick` pulse (no ticks when HAS_CASCADE is 0). 01 is one tick per system clock. 10 is one tick per 16 system clocks. 11 is one tick per falling edge of `tinPin` after synchronization.
- R4: The reference is reached when an advance makes the counter equal to the reference register. This sets event bit 0.
- R5: With mode bit 5 at 0 (free run), the counter keeps advancing past the reference and wraps from 0xFFFF to 0x0000.
- R6: With mode bit 5 at 1 (restart), the advance that reaches the reference loads 0 into the counter.
- R7: With mode bit 6 at 0, `toutN` goes low when the reference is reached and returns high on the next tick of the selected source.
- R8: With mode bit 6 at 1, `toutN` inverts each time the reference is reached.
- R9: Mode bits [3:2] choose the capture edge of `tinPin`: 01 rising, 10 falling, 11 either, 00 none. A capture copies the counter into the capture register and sets event bit 1.
- R10: `irq` is high when event bit 0 is set and mode bit 7 is 1, or when event bit 1 is set and the capture field is nonzero. Mode bit 7 has no effect on the capture part.
- R11: Event flags stay set until a one is written to their bit of the event register. Writing a zero leaves them unchanged.
- R12: With mode bit 4 at 1, counting stops while the synchronized `gatePin` is high. With mode bit 4 at 0, `gatePin` has no effect.
- R13: Writing the counter address loads the written value. Writing the mode register restarts the prescale phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 16 | Register read data, combinational |
| tinPin | input | 1 | External timer input (clock source and capture) |
| gatePin | input | 1 | Gate input, high stops counting when gating is on |
| cascadeTick | input | 1 | One-cycle tick from a partner timer |
| toutN | output | 1 | Timer output pin |
| irq | output | 1 | Interrupt request |

## Verification
A register write shows on `rdData` after the next rising edge. A change on `tinPin` or `gatePin` passes two synchronizer flops and an edge-detect flop before it acts, so a counter advance or a capture from a pin edge appears on the third rising edge after the pin changes. `toutN` and the event flags update on that same edge. The bench holds every pin level for four clock periods before a check. It only compares registers while the count source is frozen, so every expected value is exact. For bus-clock sources, where the divider phase is free, it checks the reference flag at points well before and well after the window in which it may set.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int REG_W  = 16;
  localparam int PRE_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_REF  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CAP  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_EVT  = 3'd4;

  typedef enum logic [1:0] {
    SRC_CASCADE = 2'b00,
    SRC_BUS     = 2'b01,
    SRC_BUSDIV  = 2'b10,
    SRC_PIN     = 2'b11
  } srcSel_e;

  typedef struct packed {
    logic [PRE_W-1:0] prescale;   // [15:8]
    logic             refIrqEn;   // [7]
    logic             outToggle;  // [6]
    logic             restart;    // [5]
    logic             gateEn;     // [4]
    logic [1:0]       capEdge;    // [3:2]
    srcSel_e          clkSel;     // [1:0]
  } mode_t;

  typedef struct packed {
    logic srcTick;
    logic countTick;
    logic capture;
  } strobe_t;
endpackage

// File: rtl/gpt_sync.sv
module gpt_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpt_ctrl.sv
module gpt_ctrl
  import gpt_pkg::*;
#(
  parameter int BUS_DIV     = 16,
  parameter bit HAS_CASCADE = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  mode_t   mode,
  input  logic    modeWr,
  input  logic    tinPin,
  input  logic    gatePin,
  input  logic    cascadeTick,
  output strobe_t stb
);
  localparam int DIV_W = (BUS_DIV > 1) ? $clog2(BUS_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BUS_DIV - 1);

  logic tinSync, tinPrev, gateSync;
  logic tinRise, tinFall;
  logic cascSrc, busDivTick, srcTick, running, preDone;
  logic [DIV_W-1:0] divCnt;
  logic [PRE_W-1:0] preCnt;

  gpt_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) tinSync_i (
    .clk(clk), .rstN(rstN), .din(tinPin), .dout(tinSync)
  );
  gpt_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) gateSync_i (
    .clk(clk), .rstN(rstN), .din(gatePin), .dout(gateSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tinPrev <= 1'b0;
    else       tinPrev <= tinSync;
  end

  assign tinRise = tinSync & ~tinPrev;
  assign tinFall = ~tinSync & tinPrev;

  generate
    if (HAS_CASCADE) begin : g_casc
      assign cascSrc = cascadeTick;
    end else begin : g_noCasc
      assign cascSrc = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else                       divCnt <= divCnt + 1'b1;
  end
  assign busDivTick = (divCnt == DIV_LAST);

  always_comb begin
    unique case (mode.clkSel)
      SRC_CASCADE: srcTick = cascSrc;
      SRC_BUS:     srcTick = 1'b1;
      SRC_BUSDIV:  srcTick = busDivTick;
      SRC_PIN:     srcTick = tinFall;
      default:     srcTick = 1'b0;
    endcase
  end

  assign running = !(mode.gateEn && gateSync);
  assign preDone = (preCnt == mode.prescale);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  preCnt <= '0;
    else if (modeWr)            preCnt <= '0;
    else if (running && srcTick) preCnt <= preDone ? '0 : preCnt + 1'b1;
  end

  always_comb begin
    stb.srcTick   = srcTick;
    stb.countTick = running && srcTick && preDone;
    unique case (mode.capEdge)
      2'b01:   stb.capture = tinRise;
      2'b10:   stb.capture = tinFall;
      2'b11:   stb.capture = tinRise | tinFall;
      default: stb.capture = 1'b0;
    endcase
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= mode.prescale); // R2
  AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (mode.gateEn && gateSync) |-> !stb.countTick); // R12
  AST_CAP_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (mode.capEdge == 2'b00) |-> !stb.capture); // R9
endmodule

// File: rtl/gpt_datapath.sv
module gpt_datapath
  import gpt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  output mode_t             mode,
  output logic              modeWr,
  output logic              toutN,
  output logic              irq
);
  logic [REG_W-1:0] refReg, cntReg, capReg, cntNext;
  logic refFlag, capFlag, refHit;
  logic refWr, cntWr, evtWr;

  assign modeWr = wrEn && (wrAddr == ADR_MODE);
  assign refWr  = wrEn && (wrAddr == ADR_REF);
  assign cntWr  = wrEn && (wrAddr == ADR_CNT);
  assign evtWr  = wrEn && (wrAddr == ADR_EVT);

  assign cntNext = cntReg + 1'b1;
  assign refHit  = stb.countTick && (cntNext == refReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode   <= '0;
      refReg <= '0;
    end else begin
      if (modeWr) mode   <= mode_t'(wrData);
      if (refWr)  refReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cntReg <= '0;
    else if (cntWr)         cntReg <= wrData;
    else if (stb.countTick) cntReg <= (refHit && mode.restart) ? '0 : cntNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            capReg <= '0;
    else if (stb.capture) capReg <= cntReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refFlag <= 1'b0;
      capFlag <= 1'b0;
    end else begin
      if (refHit)                     refFlag <= 1'b1;
      else if (evtWr && wrData[0])    refFlag <= 1'b0;
      if (stb.capture)                capFlag <= 1'b1;
      else if (evtWr && wrData[1])    capFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               toutN <= 1'b1;
    else if (refHit)                         toutN <= mode.outToggle ? ~toutN : 1'b0;
    else if (!mode.outToggle && stb.srcTick) toutN <= 1'b1;
  end

  assign irq = (refFlag && mode.refIrqEn) || (capFlag && (mode.capEdge != 2'b00));

  always_comb begin
    unique case (rdAddr)
      ADR_MODE: rdData = mode;
      ADR_REF:  rdData = refReg;
      ADR_CNT:  rdData = cntReg;
      ADR_CAP:  rdData = capReg;
      ADR_EVT:  rdData = {{(REG_W-2){1'b0}}, capFlag, refFlag};
      default:  rdData = '0;
    endcase
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.countTick && !cntWr) |=> $stable(cntReg)); // R13
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (refHit && mode.restart && !cntWr) |=> (cntReg == '0)); // R6
  AST_FREE_PAST: assert property (@(posedge clk) disable iff (!rstN)
    (refHit && !mode.restart && !cntWr) |=> (cntReg == $past(refReg))); // R5
  AST_REF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (refFlag && !(evtWr && wrData[0])) |=> refFlag); // R11
  AST_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (refHit && mode.outToggle) |=> (toutN != $past(toutN))); // R8
  AST_PULSE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (refHit && !mode.outToggle) |=> !toutN); // R7
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (!mode.refIrqEn && mode.capEdge == 2'b00) |-> !irq); // R10
endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
  import gpt_pkg::*;
#(
  parameter int BUS_DIV     = 16,
  parameter bit HAS_CASCADE = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  input  logic              tinPin,
  input  logic              gatePin,
  input  logic              cascadeTick,
  output logic              toutN,
  output logic              irq
);
  mode_t   mode;
  logic    modeWr;
  strobe_t stb;

  gpt_ctrl #(
    .BUS_DIV(BUS_DIV), .HAS_CASCADE(HAS_CASCADE), .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .mode(mode), .modeWr(modeWr),
    .tinPin(tinPin), .gatePin(gatePin), .cascadeTick(cascadeTick), .stb(stb)
  );

  gpt_datapath dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .mode(mode), .modeWr(modeWr), .toutN(toutN), .irq(irq)
  );
endmodule

// File: tb/gpt_timer_tb.sv
module gpt_timer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [15:0] rdData;
  logic tinPin = 1'b1;
  logic gatePin = 1'b0;
  logic cascadeTick = 1'b0;
  logic toutN, irq;

  always #10 clk = ~clk;

  gpt_timer dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .tinPin(tinPin), .gatePin(gatePin),
    .cascadeTick(cascadeTick), .toutN(toutN), .irq(irq)
  );

  typedef struct {
    int          kind;   // 0 register, 1 toutN, 2 irq
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // monitor: compares one queued item shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = rdData;
          1: act = {15'd0, toutN};
          default: act = {15'd0, irq};
        endcase
        vectors++;
        if (act !== it.exp) begin
          miscompares++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expectVal(input int kind, input logic [2:0] addr,
                           input logic [15:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    rdAddr = addr;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic regWrite(input logic [2:0] addr, input logic [15:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pinFall();
    @(negedge clk); tinPin = 1'b0; waitCycles(4);
    tinPin = 1'b1; waitCycles(4);
  endtask

  task automatic pinSet(input logic v);
    @(negedge clk); tinPin = v; waitCycles(5);
  endtask

  task automatic cascPulse();
    @(negedge clk); cascadeTick = 1'b1;
    @(negedge clk); cascadeTick = 1'b0;
    waitCycles(2);
  endtask

  function automatic logic [15:0] mk(input int pre, input int src, input int cap,
                                     input bit gate, input bit rst, input bit tog,
                                     input bit rie);
    logic [7:0] p;
    logic [1:0] s, c;
    p = pre[7:0]; s = src[1:0]; c = cap[1:0];
    return {p, rie, tog, rst, gate, c, s};
  endfunction

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);

    // R1 reset state
    expectVal(0, 3'd0, 16'h0000, "R1 mode");
    expectVal(0, 3'd1, 16'h0000, "R1 ref");
    expectVal(0, 3'd2, 16'h0000, "R1 counter");
    expectVal(0, 3'd3, 16'h0000, "R1 capture");
    expectVal(0, 3'd4, 16'h0000, "R1 event");
    expectVal(1, 3'd0, 16'h0001, "R1 toutN");
    expectVal(2, 3'd0, 16'h0000, "R1 irq");

    // R3 pin source, R13 counter write
    regWrite(3'd0, mk(0, 3, 0, 0, 0, 0, 0));
    regWrite(3'd2, 16'h0010);
    expectVal(0, 3'd2, 16'h0010, "R13 counter load");
    for (int i = 0; i < 5; i++) pinFall();
    expectVal(0, 3'd2, 16'h0015, "R3 pin falling edges");

    // R2 prescale divide by 3
    regWrite(3'd0, mk(2, 3, 0, 0, 0, 0, 0));
    regWrite(3'd2, 16'h0000);
    for (int i = 0; i < 6; i++) pinFall();
    expectVal(0, 3'd2, 16'h0002, "R2 prescale /3");
    pinFall(); pinFall();
    expectVal(0, 3'd2, 16'h0002, "R2 prescale partial");
    pinFall();
    expectVal(0, 3'd2, 16'h0003, "R2 prescale third");

    // R3 cascade source
    regWrite(3'd0, mk(0, 0, 0, 0, 0, 0, 0));
    regWrite(3'd2, 16'h0000);
    for (int i = 0; i < 3; i++) cascPulse();
    expectVal(0, 3'd2, 16'h0003, "R3 cascade ticks");

    // R4 R5 R7 free run, pulse output, R10 irq
    regWrite(3'd1, 16'h0003);
    regWrite(3'd0, mk(0, 3, 0, 0, 0, 0, 1));
    regWrite(3'd2, 16'h0000);
    pinFall(); pinFall();
    expectVal(0, 3'd4, 16'h0000, "R4 not yet reached");
    expectVal(1, 3'd0, 16'h0001, "R7 idle high");
    pinFall();
    expectVal(0, 3'd4, 16'h0001, "R4 ref flag");
    expectVal(1, 3'd0, 16'h0000, "R7 pulse low");
    expectVal(2, 3'd0, 16'h0001, "R10 ref irq");
    pinFall();
    expectVal(1, 3'd0, 16'h0001, "R7 pulse released");
    expectVal(0, 3'd2, 16'h0004, "R5 counts past ref");

    // R11 clear semantics
    regWrite(3'd4, 16'h0002);
    expectVal(0, 3'd4, 16'h0001, "R11 zero bit keeps flag");
    regWrite(3'd4, 16'h0001);
    expectVal(0, 3'd4, 16'h0000, "R11 write one clears");
    expectVal(2, 3'd0, 16'h0000, "R11 irq drops");

    // R5 wrap
    regWrite(3'd1, 16'h0005);
    regWrite(3'd2, 16'hFFFE);
    pinFall(); pinFall();
    expectVal(0, 3'd2, 16'h0000, "R5 wrap to zero");

    // R6 restart, R8 toggle
    regWrite(3'd1, 16'h0004);
    regWrite(3'd0, mk(0, 3, 0, 0, 1, 1, 1));
    regWrite(3'd2, 16'h0000);
    for (int i = 0; i < 4; i++) pinFall();
    expectVal(0, 3'd2, 16'h0000, "R6 restart to zero");
    expectVal(1, 3'd0, 16'h0000, "R8 toggle low");
    pinFall();
    expectVal(1, 3'd0, 16'h0000, "R8 toggle holds");
    expectVal(0, 3'd2, 16'h0001, "R6 counts after restart");
    for (int i = 0; i < 3; i++) pinFall();
    expectVal(1, 3'd0, 16'h0001, "R8 toggle high");
    regWrite(3'd4, 16'h0003);

    // R10 ref enable off
    regWrite(3'd0, mk(0, 3, 0, 0, 1, 0, 0));
    regWrite(3'd2, 16'h0003);
    pinFall();
    expectVal(0, 3'd4, 16'h0001, "R10 flag without enable");
    expectVal(2, 3'd0, 16'h0000, "R10 irq masked");
    regWrite(3'd4, 16'h0001);

    // R12 gate
    regWrite(3'd0, mk(0, 3, 0, 1, 0, 0, 0));
    regWrite(3'd2, 16'h0100);
    @(negedge clk); gatePin = 1'b1; waitCycles(4);
    pinFall(); pinFall(); pinFall();
    expectVal(0, 3'd2, 16'h0100, "R12 gated hold");
    @(negedge clk); gatePin = 1'b0; waitCycles(4);
    pinFall(); pinFall();
    expectVal(0, 3'd2, 16'h0102, "R12 gate open");
    @(negedge clk); gatePin = 1'b1; waitCycles(4);
    regWrite(3'd0, mk(0, 3, 0, 0, 0, 0, 0));
    pinFall(); pinFall();
    expectVal(0, 3'd2, 16'h0104, "R12 gate ignored");
    @(negedge clk); gatePin = 1'b0; waitCycles(4);

    // R9 capture, counter frozen on cascade source
    regWrite(3'd0, mk(0, 0, 1, 0, 0, 0, 0));
    regWrite(3'd2, 16'h1234);
    pinSet(1'b0);
    expectVal(0, 3'd4, 16'h0000, "R9 rise-only ignores fall");
    pinSet(1'b1);
    expectVal(0, 3'd3, 16'h1234, "R9 rising capture");
    expectVal(0, 3'd4, 16'h0002, "R9 capture flag");
    expectVal(2, 3'd0, 16'h0001, "R10 capture irq without ref enable");
    regWrite(3'd4, 16'h0002);
    regWrite(3'd0, mk(0, 0, 2, 0, 0, 0, 0));
    regWrite(3'd2, 16'h2222);
    pinSet(1'b0);
    expectVal(0, 3'd3, 16'h2222, "R9 falling capture");
    regWrite(3'd2, 16'h2a2a);
    pinSet(1'b1);
    expectVal(0, 3'd3, 16'h2222, "R9 fall-only ignores rise");
    regWrite(3'd4, 16'h0002);
    regWrite(3'd0, mk(0, 0, 0, 0, 0, 0, 0));
    regWrite(3'd2, 16'h3333);
    pinSet(1'b0); pinSet(1'b1);
    expectVal(0, 3'd3, 16'h2222, "R9 disabled keeps capture");
    expectVal(0, 3'd4, 16'h0000, "R9 disabled no flag");
    regWrite(3'd0, mk(0, 0, 3, 0, 0, 0, 0));
    regWrite(3'd2, 16'h4444);
    pinSet(1'b0);
    expectVal(0, 3'd3, 16'h4444, "R9 either edge fall");
    regWrite(3'd2, 16'h5555);
    pinSet(1'b1);
    expectVal(0, 3'd3, 16'h5555, "R9 either edge rise");
    regWrite(3'd4, 16'h0002);

    // R3 bus clock: reference 20 reached 20 cycles after mode write
    regWrite(3'd1, 16'd20);
    regWrite(3'd2, 16'h0000);
    regWrite(3'd0, mk(0, 1, 0, 0, 0, 0, 0));
    waitCycles(8);
    expectVal(0, 3'd4, 16'h0000, "R3 bus clock early");
    waitCycles(20);
    expectVal(0, 3'd4, 16'h0001, "R3 bus clock reached");
    regWrite(3'd0, mk(0, 0, 0, 0, 0, 0, 0));
    regWrite(3'd4, 16'h0001);

    // R3 bus clock / 16: reference 5 reached 65..80 cycles after start
    regWrite(3'd1, 16'd5);
    regWrite(3'd2, 16'h0000);
    regWrite(3'd0, mk(0, 2, 0, 0, 0, 0, 0));
    waitCycles(50);
    expectVal(0, 3'd4, 16'h0000, "R3 div16 early");
    waitCycles(50);
    expectVal(0, 3'd4, 16'h0001, "R3 div16 reached");

    waitCycles(3);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule